// File: doc/BRIEF.md
# Interrupt Input Pending Bank

This block keeps the per-line state of a core-local interrupt controller for a parameterised number of interrupt inputs. Each line has four pieces of state: a pending flag, an enable flag, an attribute byte and a control byte. The attribute byte holds the vectored flag, the trigger type, the input polarity and the privilege mode. A priority arbiter elsewhere in the controller reads every field through flat output vectors. This block does no priority selection.

External lines first pass through a two-flop synchroniser. The polarity bit then inverts the line where needed. A level-triggered line copies the adjusted input into its pending flag. An edge-triggered line latches pending on a rising transition of the adjusted input and holds it until it is cleared. Software changes the state with single-byte writes, and four consecutive bytes belong to each line. When the core reports that it has taken a line, that line's pending flag is cleared if the line is edge-triggered.

Each line behaves as a two-state machine chosen by its trigger bit: FOLLOW (level) and LATCH (edge). Writing the trigger bit is the only transition between them, FOLLOW→LATCH or LATCH→FOLLOW. Inside LATCH, the pending flag moves IDLE→SET on a rising adjusted input or a software write of 1. It moves SET→IDLE on a take or a software write of 0.

Top module: `irq_pend_bank`

## Requirements
- R1: After reset, every line has pending 0, enable 0, attribute 0xC0 and control equal to the fill mask (the low 8−CTL_BITS bits set, all other bits 0).
- R2: Line i owns byte addresses 0x1000+4i+k. Lane k=0 is pending (bit 0), k=1 is enable (bit 0), k=2 is attribute and k=3 is control. A write to an address below 0x1000 or at or above 0x1000+4·NUM_IRQ changes no state.
- R3: In the attribute byte, bit 0 is vectored, bit 1 is edge-triggered (1 = edge), bit 2 is negative polarity and bits 7:6 are the mode. Bits 5:3 always read 0.
- R4: A control write stores the written byte with its low 8−CTL_BITS bits forced to 1.
- R5: For a level-triggered line, pending equals the line input XOR the negative bit. A change at the input appears on pending at the third rising clock edge after the change.
- R6: For an edge-triggered line, pending sets when the synchronised, polarity-adjusted input goes from 0 to 1. It stays set after the input returns to 0.
- R7: A software write to the pending byte of a level-triggered line is ignored.
- R8: A software write to the pending byte of an edge-triggered line sets or clears pending according to bit 0.
- R9: When take_i is asserted with take_idx_i = i, pending of line i clears if the line is edge-triggered. It is unchanged if the line is level-triggered.
- R10: On an edge-triggered line, a rising adjusted input in the same cycle as a take or a software clear leaves pending set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| irq_i | input | NUM_IRQ | Asynchronous interrupt lines |
| wr_en_i | input | 1 | Byte write strobe |
| wr_addr_i | input | ADDR_W | Byte write address |
| wr_data_i | input | 8 | Byte write data |
| take_i | input | 1 | Core has taken the selected interrupt |
| take_idx_i | input | IDX_W | Index of the taken interrupt |
| pend_o | output | NUM_IRQ | Pending flags |
| en_o | output | NUM_IRQ | Enable flags |
| attr_o | output | 8·NUM_IRQ | Attribute bytes, line i at [8i+7:8i] |
| ctl_o | output | 8·NUM_IRQ | Control bytes, line i at [8i+7:8i] |

## Verification
Some rules are checked on every cycle. A level line's pending must match the previous cycle's adjusted input. A latched pending flag may drop only on a take or a software write. A rising input always leaves pending set, even when a clear arrives in the same cycle. The reserved attribute bits and the forced control bits never change. Other behaviour is shown only by the bench's scenarios: the three-edge input latency, the byte-lane address decode and its out-of-range rejection, the reset values, and take-driven clearing as seen at the ports.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
    localparam logic [15:0] SLOT_BASE = 16'h1000;
    localparam logic [7:0]  ATTR_RST  = 8'hC0;
    localparam logic [7:0]  ATTR_KEEP = 8'hC7;

    typedef enum logic [1:0] {
        LANE_PEND = 2'd0,
        LANE_EN   = 2'd1,
        LANE_ATTR = 2'd2,
        LANE_CTL  = 2'd3
    } lane_e;

    typedef enum logic {
        TRIG_FOLLOW = 1'b0,
        TRIG_LATCH  = 1'b1
    } trig_e;

    function automatic logic [7:0] ctl_fill(input int unsigned bits);
        logic [7:0] m;
        m = '0;
        for (int b = 0; b < 8; b++) begin
            if (b < 8 - int'(bits)) m[b] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stab_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= async_i;
            stab_q <= meta_q;
        end
    end

    assign sync_o = stab_q;
endmodule

// File: rtl/irq_slot.sv
module irq_slot
    import irq_pend_pkg::*;
#(
    parameter int CTL_BITS = 6
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       line_i,
    input  logic       wr_pend_i,
    input  logic       wr_en_i,
    input  logic       wr_attr_i,
    input  logic       wr_ctl_i,
    input  logic [7:0] wdata_i,
    input  logic       take_i,
    output logic       pend_o,
    output logic       en_o,
    output logic [7:0] attr_o,
    output logic [7:0] ctl_o
);
    localparam logic [7:0] FILL = ctl_fill(CTL_BITS);

    logic       pend_q, en_q, prev_q;
    logic [7:0] attr_q, ctl_q;
    logic       act, rise, pend_d;
    trig_e      mode;

    assign mode = attr_q[1] ? TRIG_LATCH : TRIG_FOLLOW;
    assign act  = line_i ^ attr_q[2];
    assign rise = act & ~prev_q;

    always_comb begin
        pend_d = pend_q;
        unique case (mode)
            TRIG_FOLLOW: pend_d = act;
            TRIG_LATCH: begin
                if (rise)           pend_d = 1'b1;
                else if (take_i)    pend_d = 1'b0;
                else if (wr_pend_i) pend_d = wdata_i[0];
            end
            default: pend_d = pend_q;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pend_q <= 1'b0;
            en_q   <= 1'b0;
            prev_q <= 1'b0;
            attr_q <= ATTR_RST;
            ctl_q  <= FILL;
        end else begin
            pend_q <= pend_d;
            prev_q <= act;
            if (wr_en_i)   en_q   <= wdata_i[0];
            if (wr_attr_i) attr_q <= wdata_i & ATTR_KEEP;
            if (wr_ctl_i)  ctl_q  <= wdata_i | FILL;
        end
    end

    assign pend_o = pend_q;
    assign en_o   = en_q;
    assign attr_o = attr_q;
    assign ctl_o  = ctl_q;

    a_r5_level_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(!attr_q[1]) |-> pend_q == $past(line_i ^ attr_q[2]));
    a_r6_latch_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(attr_q[1] && pend_q && !take_i && !wr_pend_i) |-> pend_q);
    a_r9_take_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(attr_q[1] && take_i && !(act && !prev_q)) |-> !pend_q);
    a_r10_rise_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(attr_q[1] && act && !prev_q) |-> pend_q);
    a_r3_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        attr_o[5:3] == 3'b000);
    a_r4_fill_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_o & FILL) == FILL);
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
    import irq_pend_pkg::*;
#(
    parameter int NUM_IRQ  = 8,
    parameter int CTL_BITS = 6,
    parameter int ADDR_W   = 16,
    parameter int IDX_W    = $clog2(NUM_IRQ)
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_IRQ-1:0]   irq_i,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    wr_addr_i,
    input  logic [7:0]           wr_data_i,
    input  logic                 take_i,
    input  logic [IDX_W-1:0]     take_idx_i,
    output logic [NUM_IRQ-1:0]   pend_o,
    output logic [NUM_IRQ-1:0]   en_o,
    output logic [8*NUM_IRQ-1:0] attr_o,
    output logic [8*NUM_IRQ-1:0] ctl_o
);
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(SLOT_BASE);

    logic [NUM_IRQ-1:0] line_s;
    logic [ADDR_W-1:0]  off;
    logic               hit;
    lane_e              lane;
    logic [3:0]         lane_sel;

    irq_sync #(.WIDTH(NUM_IRQ)) i_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (irq_i),
        .sync_o  (line_s)
    );

    assign off  = wr_addr_i - BASE;
    assign hit  = wr_en_i && (wr_addr_i >= BASE) &&
                  (off[ADDR_W-1:2] < (ADDR_W-2)'(NUM_IRQ));
    assign lane = lane_e'(off[1:0]);

    always_comb begin
        lane_sel = 4'b0000;
        unique case (lane)
            LANE_PEND: lane_sel[0] = hit;
            LANE_EN:   lane_sel[1] = hit;
            LANE_ATTR: lane_sel[2] = hit;
            LANE_CTL:  lane_sel[3] = hit;
            default:   lane_sel    = 4'b0000;
        endcase
    end

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_slot
        logic mine;
        assign mine = (off[ADDR_W-1:2] == (ADDR_W-2)'(g));
        irq_slot #(.CTL_BITS(CTL_BITS)) i_slot (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .line_i    (line_s[g]),
            .wr_pend_i (mine && lane_sel[0]),
            .wr_en_i   (mine && lane_sel[1]),
            .wr_attr_i (mine && lane_sel[2]),
            .wr_ctl_i  (mine && lane_sel[3]),
            .wdata_i   (wr_data_i),
            .take_i    (take_i && (take_idx_i == IDX_W'(g))),
            .pend_o    (pend_o[g]),
            .en_o      (en_o[g]),
            .attr_o    (attr_o[8*g +: 8]),
            .ctl_o     (ctl_o[8*g +: 8])
        );
    end

    a_r2_one_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(lane_sel));
endmodule

// File: tb/test_irq_pend_bank.sv
module test_irq_pend_bank;
    localparam int N  = 8;
    localparam int CB = 6;
    localparam int IW = $clog2(N);
    localparam logic [7:0] FILL = 8'h03;

    logic clk = 0, rst_n = 0;
    logic [N-1:0] irq = '0;
    logic we = 0;
    logic [15:0] addr = '0;
    logic [7:0] data = '0;
    logic take = 0;
    logic [IW-1:0] tidx = '0;
    logic [N-1:0] pend, en;
    logic [8*N-1:0] attr, ctl;
    int checks = 0, fails = 0;
    logic [7:0] neg_m;

    always #5 clk = ~clk;

    irq_pend_bank #(.NUM_IRQ(N), .CTL_BITS(CB)) i_irq_pend_bank (
        .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .wr_en_i(we),
        .wr_addr_i(addr), .wr_data_i(data), .take_i(take),
        .take_idx_i(tidx), .pend_o(pend), .en_o(en), .attr_o(attr), .ctl_o(ctl));

    function automatic logic [7:0] exp_attr(input logic [7:0] d);
        return d & 8'hC7;
    endfunction
    function automatic logic [7:0] exp_ctl(input logic [7:0] d);
        return d | FILL;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk); we = 1; addr = a; data = d;
        @(negedge clk); we = 0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_take(input int i);
        @(negedge clk); take = 1; tidx = IW'(i);
        @(negedge clk); take = 0;
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        wait_n(3); rst_n = 1; wait_n(1);
        // R1 reset values
        chk("R1 pend", 64'(pend), 0);
        chk("R1 en", 64'(en), 0);
        for (int i = 0; i < N; i++) begin
            chk("R1 attr", 64'(attr[8*i +: 8]), 64'h C0);
            chk("R1 ctl", 64'(ctl[8*i +: 8]), 64'(FILL));
        end
        // R2 R3 lane decode and attribute masking
        wr(16'h1000 + 4*2 + 2, 8'hFF);
        chk("R3 attr mask", 64'(attr[16 +: 8]), 64'hC7);
        wr(16'h1000 + 4*2 + 3, 8'h00);
        chk("R4 ctl fill", 64'(ctl[16 +: 8]), 64'(FILL));
        wr(16'h1000 + 4*2 + 1, 8'h01);
        chk("R2 enable lane", 64'(en), 64'h04);
        wr(16'h1000 + 4*2 + 2, 8'hC0);
        // R5 level follow with latency
        @(negedge clk); irq[1] = 1;
        wait_n(2);
        chk("R5 not yet", 64'(pend[1]), 0);
        wait_n(1);
        chk("R5 level high", 64'(pend[1]), 1);
        wr(16'h1000 + 4*1 + 2, 8'hC4);
        wait_n(1);
        chk("R5 negative", 64'(pend[1]), 0);
        // R7 software write ignored on level line
        wr(16'h1000 + 4*1 + 0, 8'h01);
        chk("R7 level sw", 64'(pend[1]), 0);
        // R6 edge latch
        wr(16'h1000 + 4*3 + 2, 8'hC2);
        @(negedge clk); irq[3] = 1; wait_n(3);
        chk("R6 edge set", 64'(pend[3]), 1);
        @(negedge clk); irq[3] = 0; wait_n(3);
        chk("R6 edge hold", 64'(pend[3]), 1);
        // R9 take
        do_take(3);
        chk("R9 take edge", 64'(pend[3]), 0);
        @(negedge clk); irq[1] = 0; wait_n(3);
        chk("R9 level pre", 64'(pend[1]), 1);
        do_take(1);
        chk("R9 take level", 64'(pend[1]), 1);
        // R8 software on edge line
        wr(16'h1000 + 4*3 + 0, 8'h01);
        chk("R8 sw set", 64'(pend[3]), 1);
        wr(16'h1000 + 4*3 + 0, 8'h00);
        chk("R8 sw clr", 64'(pend[3]), 0);
        // R10 rise coincides with take
        wr(16'h1000 + 4*3 + 0, 8'h01);
        @(negedge clk); irq[3] = 1;
        wait_n(2);
        take = 1; tidx = 3;
        @(negedge clk); take = 0;
        chk("R10 rise wins", 64'(pend[3]), 1);
        // R2 out-of-range writes
        for (int k = 0; k < 20; k++) begin
            logic [N-1:0] p0, e0;
            logic [8*N-1:0] a0, c0;
            logic [15:0] oa;
            oa = ($urandom % 2) ? 16'(16'h0FF0 + ($urandom % 16))
                                : 16'(16'h1000 + 4*N + ($urandom % 64));
            p0 = pend; e0 = en; a0 = attr; c0 = ctl;
            wr(oa, 8'($urandom));
            chk("R2 out of range", {pend, en}, {p0, e0});
            chk("R2 out of range", 64'(attr ^ a0) | 64'(ctl ^ c0), 0);
        end
        // R3 R4 random attribute/control writes (level only, bit1 cleared)
        for (int k = 0; k < 60; k++) begin
            int i;
            logic [7:0] d;
            i = $urandom % N; d = 8'($urandom);
            if ($urandom % 2) begin
                d[1] = 1'b0;
                wr(16'(16'h1000 + 4*i + 2), d);
                chk("R3 random attr", 64'(attr[8*i +: 8]), 64'(exp_attr(d)));
            end else begin
                wr(16'(16'h1000 + 4*i + 3), d);
                chk("R4 random ctl", 64'(ctl[8*i +: 8]), 64'(exp_ctl(d)));
            end
        end
        // R5 random level patterns with random polarity
        for (int i = 0; i < N; i++) begin
            neg_m[i] = 1'($urandom);
            wr(16'(16'h1000 + 4*i + 2), neg_m[i] ? 8'hC4 : 8'hC0);
        end
        for (int k = 0; k < 30; k++) begin
            @(negedge clk); irq = N'($urandom);
            wait_n(3);
            chk("R5 random level", 64'(pend), 64'(irq ^ neg_m));
        end
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule